// File: doc/BRIEF.md
# Counted Stream Frame Gate

This block sits between a stream source that never stops and never marks frame ends (a tone generator, say) and a consumer that writes stream beats into memory and needs a frame end marker. Software programs a beat count N through a one-cycle write strobe with a data word. That write arms the gate. The gate then waits until the consumer first shows ready. After that it forwards exactly N beats, flags the final beat with TLAST and closes again.

When the gate is closed, the source is drained: its ready is held high and its beats are thrown away, so the source never stalls. While a frame is open, the handshake passes straight through. A beat is forwarded and counted only on a cycle where the source is valid and the consumer is ready. A count written during an open frame is kept as pending and arms the next frame as soon as the current one ends. The data word and all sideband fields travel through unchanged.

Top module: `axis_frame_gate`

## Requirements
- R1: `state_o` encodes 0 for closed, 1 for armed and 2 for open. A `cfg_wr` pulse while closed moves `state_o` to 1 on the next cycle.
- R2: While armed, no beat is forwarded. The gate stays armed until it samples `m_tready` high at a clock edge, and it is open from the following cycle.
- R3: While closed or armed, `m_tvalid` is 0 and `s_tready` is 1, so input beats are discarded.
- R4: While open, `m_tvalid` follows `s_tvalid` and `s_tready` follows `m_tready`. A beat is accepted when both are high.
- R5: The internal count advances only on an accepted beat. `m_tlast` is 1 on the N-th accepted beat of a frame and 0 on every earlier one.
- R6: A programmed N of 0 yields a frame of exactly one beat, and that beat carries `m_tlast`.
- R7: `done_o` is 1 exactly in the cycle in which the beat carrying `m_tlast` is accepted. If no count is pending, `state_o` is 0 on the next cycle.
- R8: On every forwarded beat, `m_tdata`, `m_tkeep`, `m_tstrb`, `m_tuser`, `m_tid` and `m_tdest` equal their `s_` counterparts.
- R9: A `cfg_wr` while open does not change the current frame. It is held as pending, with the latest write winning. After the last-beat handshake, the gate goes to armed with the pending count. A `cfg_wr` while armed replaces the armed count.
- R10: Synchronous active-high `rst` returns the gate to closed with a zero count and no pending count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | One-cycle count write strobe |
| cfg_count | input | CNT_W | Beats per frame (N) |
| s_tvalid | input | 1 | Source beat valid |
| s_tready | output | 1 | Ready to the source |
| s_tdata | input | DATA_W | Source data |
| s_tkeep | input | DATA_W/8 | Source byte keep |
| s_tstrb | input | DATA_W/8 | Source byte strobe |
| s_tuser | input | USER_W | Source user field |
| s_tid | input | ID_W | Source stream id |
| s_tdest | input | DEST_W | Source routing field |
| m_tvalid | output | 1 | Forwarded beat valid |
| m_tready | input | 1 | Consumer ready |
| m_tdata | output | DATA_W | Forwarded data |
| m_tkeep | output | DATA_W/8 | Forwarded byte keep |
| m_tstrb | output | DATA_W/8 | Forwarded byte strobe |
| m_tuser | output | USER_W | Forwarded user field |
| m_tid | output | ID_W | Forwarded stream id |
| m_tdest | output | DEST_W | Forwarded routing field |
| m_tlast | output | 1 | Marks the final beat of a frame |
| state_o | output | 2 | Gate state: 0 closed, 1 armed, 2 open |
| done_o | output | 1 | Pulse with the accepted last beat |

## Verification
Some properties are checked on every cycle:
- The gate stays silent and drains the source whenever it is not open.
- An armed gate waits while ready is low.
- The count holds on stalled cycles and never passes the compare value.
- A pending count survives until the frame ends.
- The gate leaves the open state after a done pulse.

Other behaviour needs a behavioural reference model driven through scenarios and compared on every cycle:
- Frame lengths under random backpressure.
- The one-beat frame for a zero count.
- The order in which pending and armed counts take effect.
- Rewrites that land on the exact last-beat cycle.
- Recovery after a reset in the middle of a frame.

// File: rtl/frame_gate_pkg.sv
package frame_gate_pkg;

    typedef enum logic [1:0] {
        GATE_IDLE  = 2'd0,
        GATE_ARMED = 2'd1,
        GATE_RUN   = 2'd2
    } gate_state_e;

    // Converts a programmed beat count into the value the counter is
    // compared with. Zero is folded onto a single-beat frame.
    function automatic logic [31:0] terminal_of(input logic [31:0] beats);
        return (beats == 32'd0) ? 32'd0 : beats - 32'd1;
    endfunction

endpackage

// File: rtl/gate_fsm.sv
module gate_fsm
    import frame_gate_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             m_tready,
    input  logic             last_fire,
    output gate_state_e      state,
    output logic [CNT_W-1:0] limit
);

    logic [CNT_W-1:0] wr_term;
    logic             pend_vld;
    logic [CNT_W-1:0] pend_lim;

    assign wr_term = CNT_W'(terminal_of(32'(cfg_count)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= GATE_IDLE;
            limit    <= '0;
            pend_vld <= 1'b0;
            pend_lim <= '0;
        end else begin
            unique case (state)
                GATE_IDLE: begin
                    if (cfg_wr) begin
                        limit <= wr_term;
                        state <= GATE_ARMED;
                    end
                end
                GATE_ARMED: begin
                    if (cfg_wr) limit <= wr_term;
                    if (m_tready) state <= GATE_RUN;
                end
                GATE_RUN: begin
                    if (last_fire) begin
                        pend_vld <= 1'b0;
                        if (cfg_wr) begin
                            limit <= wr_term;
                            state <= GATE_ARMED;
                        end else if (pend_vld) begin
                            limit <= pend_lim;
                            state <= GATE_ARMED;
                        end else begin
                            state <= GATE_IDLE;
                        end
                    end else if (cfg_wr) begin
                        pend_vld <= 1'b1;
                        pend_lim <= wr_term;
                    end
                end
                default: state <= GATE_IDLE;
            endcase
        end
    end

    // R1
    arm_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == GATE_IDLE && cfg_wr) |=> (state == GATE_ARMED))
        else $error("closed gate did not arm after a count write");

    // R2
    armed_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == GATE_ARMED && !m_tready) |=> (state == GATE_ARMED))
        else $error("armed gate left armed without consumer ready");

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == GATE_RUN && pend_vld && !last_fire) |=> pend_vld)
        else $error("pending count lost during an open frame");

    // R9
    limit_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (state == GATE_RUN && !last_fire) |=> $stable(limit))
        else $error("frame length changed while open");

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (state == GATE_IDLE && !pend_vld))
        else $error("reset did not return to closed");

    // R1
    state_legal_chk: assert property (@(posedge clk) disable iff (rst)
        state != 2'd3)
        else $error("illegal state code");

endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [CNT_W-1:0] limit,
    output logic             at_limit
);

    logic [CNT_W-1:0] cnt;

    assign at_limit = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= at_limit ? '0 : cnt + CNT_W'(1);
        end
    end

    // R5
    cnt_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(cnt))
        else $error("beat count moved without a handshake");

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit)
        else $error("beat count passed the compare value");

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
    import frame_gate_pkg::*;
#(
    parameter int unsigned SB_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  gate_state_e     state,
    input  logic            s_tvalid,
    input  logic            m_tready,
    input  logic            at_limit,
    input  logic [SB_W-1:0] s_sb,
    output logic            s_tready,
    output logic            m_tvalid,
    output logic            m_tlast,
    output logic            fire,
    output logic            last_fire,
    output logic [SB_W-1:0] m_sb
);

    logic running;

    assign running   = (state == GATE_RUN);
    assign m_tvalid  = running & s_tvalid;
    assign s_tready  = running ? m_tready : 1'b1;
    assign fire      = m_tvalid & m_tready;
    assign m_tlast   = running & at_limit;
    assign last_fire = fire & at_limit;

    // Payload and sideband travel in one packed word, copied bit for bit.
    for (genvar b = 0; b < SB_W; b++) begin : g_sb
        assign m_sb[b] = s_sb[b];
    end

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state != GATE_RUN) |-> (!m_tvalid && s_tready))
        else $error("closed gate forwarded or stalled the source");

    // R7
    done_exit_chk: assert property (@(posedge clk) disable iff (rst)
        last_fire |=> (state != GATE_RUN))
        else $error("gate stayed open after the last beat");

endmodule

// File: rtl/axis_frame_gate.sv
module axis_frame_gate
    import frame_gate_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned USER_W = 4,
    parameter int unsigned ID_W   = 5,
    parameter int unsigned DEST_W = 6,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [CNT_W-1:0]      cfg_count,
    input  logic                  s_tvalid,
    output logic                  s_tready,
    input  logic [DATA_W-1:0]     s_tdata,
    input  logic [DATA_W/8-1:0]   s_tkeep,
    input  logic [DATA_W/8-1:0]   s_tstrb,
    input  logic [USER_W-1:0]     s_tuser,
    input  logic [ID_W-1:0]       s_tid,
    input  logic [DEST_W-1:0]     s_tdest,
    output logic                  m_tvalid,
    input  logic                  m_tready,
    output logic [DATA_W-1:0]     m_tdata,
    output logic [DATA_W/8-1:0]   m_tkeep,
    output logic [DATA_W/8-1:0]   m_tstrb,
    output logic [USER_W-1:0]     m_tuser,
    output logic [ID_W-1:0]       m_tid,
    output logic [DEST_W-1:0]     m_tdest,
    output logic                  m_tlast,
    output logic [1:0]            state_o,
    output logic                  done_o
);

    localparam int unsigned KEEP_W = DATA_W / 8;
    localparam int unsigned SB_W   = DATA_W + 2 * KEEP_W + USER_W + ID_W + DEST_W;

    gate_state_e      state;
    logic [CNT_W-1:0] limit;
    logic             at_limit;
    logic             fire;
    logic             last_fire;
    logic [SB_W-1:0]  s_sb;
    logic [SB_W-1:0]  m_sb;

    assign s_sb = {s_tdata, s_tkeep, s_tstrb, s_tuser, s_tid, s_tdest};
    assign {m_tdata, m_tkeep, m_tstrb, m_tuser, m_tid, m_tdest} = m_sb;
    assign state_o = state;
    assign done_o  = last_fire;

    gate_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_count (cfg_count),
        .m_tready  (m_tready),
        .last_fire (last_fire),
        .state     (state),
        .limit     (limit)
    );

    beat_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .limit    (limit),
        .at_limit (at_limit)
    );

    gate_datapath #(.SB_W(SB_W)) dp_i (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .s_tvalid  (s_tvalid),
        .m_tready  (m_tready),
        .at_limit  (at_limit),
        .s_sb      (s_sb),
        .s_tready  (s_tready),
        .m_tvalid  (m_tvalid),
        .m_tlast   (m_tlast),
        .fire      (fire),
        .last_fire (last_fire),
        .m_sb      (m_sb)
    );

endmodule

// File: tb/axis_frame_gate_tb_top.sv
`timescale 1ns/1ps
module axis_frame_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_count = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [31:0] s_tdata = '0;
    logic [3:0]  s_tkeep = '0;
    logic [3:0]  s_tstrb = '0;
    logic [3:0]  s_tuser = '0;
    logic [4:0]  s_tid = '0;
    logic [5:0]  s_tdest = '0;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep;
    logic [3:0]  m_tstrb;
    logic [3:0]  m_tuser;
    logic [4:0]  m_tid;
    logic [5:0]  m_tdest;
    logic        m_tlast;
    logic [1:0]  state_o;
    logic        done_o;

    always #2 clk = ~clk;

    axis_frame_gate dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tstrb(s_tstrb), .s_tuser(s_tuser),
        .s_tid(s_tid), .s_tdest(s_tdest), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
        .m_tstrb(m_tstrb), .m_tuser(m_tuser), .m_tid(m_tid),
        .m_tdest(m_tdest), .m_tlast(m_tlast), .state_o(state_o),
        .done_o(done_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Behavioural reference state
    int m_state = 0;
    int m_cnt = 0;
    int m_lim = 0;
    int pend_q[$];
    int exp_len = 0;
    int obs_beats = 0;
    int last_len = 0;
    bit after_reset = 1'b0;

    function automatic int term(input int n);
        return (n == 0) ? 0 : n - 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        cfg_wr = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
        m_state = 0; m_cnt = 0; m_lim = 0; pend_q.delete();
        obs_beats = 0;
        rst = 1'b0;
        after_reset = 1'b1;
    endtask

    // One clock: drive, compare against the model, advance the model.
    task automatic step(input bit wr, input int cv, input bit sv, input bit mr);
        bit run, fire, lastb;
        @(negedge clk);
        cfg_wr = wr; cfg_count = 16'(cv); s_tvalid = sv; m_tready = mr;
        s_tdata = $urandom; s_tkeep = 4'($urandom); s_tstrb = 4'($urandom);
        s_tuser = 4'($urandom); s_tid = 5'($urandom); s_tdest = 6'($urandom);
        #1;
        run   = (m_state == 2);
        fire  = run && sv && mr;
        lastb = fire && (m_cnt == m_lim);
        chk(longint'(state_o) == longint'(m_state), after_reset ? "R10" : "R1",
            "state_o", longint'(state_o), longint'(m_state));
        chk(m_tvalid == (run ? sv : 1'b0), run ? "R4" : "R3", "m_tvalid",
            longint'(m_tvalid), longint'(run ? sv : 1'b0));
        chk(s_tready == (run ? mr : 1'b1), run ? "R4" : "R3", "s_tready",
            longint'(s_tready), longint'(run ? mr : 1'b1));
        chk(done_o == lastb, "R7", "done_o", longint'(done_o), longint'(lastb));
        if (run && sv) begin
            chk(m_tlast == (m_cnt == m_lim), "R5", "m_tlast",
                longint'(m_tlast), longint'(m_cnt == m_lim));
            chk(m_tdata == s_tdata && m_tkeep == s_tkeep && m_tstrb == s_tstrb &&
                m_tuser == s_tuser && m_tid == s_tid && m_tdest == s_tdest,
                "R8", "sideband mismatch, m_tdata", longint'(m_tdata), longint'(s_tdata));
        end
        after_reset = 1'b0;
        // frame length as seen at the ports
        if (m_tvalid && mr) begin
            obs_beats++;
            if (m_tlast) begin
                chk(obs_beats == exp_len, "R5", "frame length", obs_beats, exp_len);
                last_len = obs_beats;
                obs_beats = 0;
            end
        end
        // model advance
        case (m_state)
            0: if (wr) begin m_lim = term(cv); m_state = 1; end
            1: begin
                if (wr) m_lim = term(cv);
                if (mr) begin m_state = 2; exp_len = m_lim + 1; end
            end
            default: begin
                if (lastb) begin
                    m_cnt = 0;
                    if (wr) begin
                        m_lim = term(cv); m_state = 1; pend_q.delete();
                    end else if (pend_q.size() > 0) begin
                        m_lim = pend_q.pop_front(); m_state = 1;
                    end else begin
                        m_state = 0;
                    end
                end else begin
                    if (fire) m_cnt++;
                    if (wr) begin pend_q.delete(); pend_q.push_back(term(cv)); end
                end
            end
        endcase
    endtask

    task automatic run_random(input int n, input int pv, input int pr);
        for (int i = 0; i < n; i++)
            step(1'b0, 0, ($urandom_range(99) < pv), ($urandom_range(99) < pr));
    endtask

    initial begin : watchdog
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin : stim
        do_reset(3);
        // R10 reset state, then R3 drain while closed
        for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b1, 1'b1);

        // R1/R2: arm with N=5, hold ready low, then stream
        step(1'b1, 5, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b1, 1'b0);
        run_random(20, 100, 100);
        chk(last_len == 5, "R5", "N=5 frame", last_len, 5);

        // R3: no forwarding after the frame without a new write
        run_random(6, 100, 100);

        // R6: zero count gives one beat
        step(1'b1, 0, 1'b0, 1'b1);
        run_random(6, 100, 100);
        chk(last_len == 1, "R6", "N=0 frame", last_len, 1);

        step(1'b1, 1, 1'b0, 1'b1);
        run_random(6, 100, 100);
        chk(last_len == 1, "R5", "N=1 frame", last_len, 1);

        // R4/R5 under backpressure and gaps
        step(1'b1, 20, 1'b0, 1'b1);
        run_random(120, 60, 55);
        chk(last_len == 20, "R5", "N=20 frame", last_len, 20);

        // R9: write during open frame is pending
        step(1'b1, 6, 1'b1, 1'b1);
        step(1'b0, 0, 1'b1, 1'b1);
        step(1'b0, 0, 1'b1, 1'b1);
        step(1'b1, 3, 1'b1, 1'b1);
        run_random(6, 100, 100);
        chk(last_len == 6, "R9", "current frame kept", last_len, 6);
        run_random(8, 100, 100);
        chk(last_len == 3, "R9", "pending frame", last_len, 3);

        // R9: rewrite while armed replaces the count
        step(1'b1, 9, 1'b1, 1'b0);
        step(1'b1, 2, 1'b1, 1'b0);
        run_random(10, 100, 100);
        chk(last_len == 2, "R9", "armed rewrite", last_len, 2);

        // Random mix of writes, gaps and stalls
        for (int i = 0; i < 600; i++)
            step(($urandom_range(99) < 6), $urandom_range(7),
                 ($urandom_range(99) < 70), ($urandom_range(99) < 70));

        // R10: reset in the middle of a frame
        step(1'b1, 30, 1'b1, 1'b1);
        run_random(5, 100, 100);
        step(1'b1, 4, 1'b1, 1'b1);
        do_reset(2);
        step(1'b0, 0, 1'b1, 1'b1);
        chk(state_o == 2'd0, "R10", "state after reset", longint'(state_o), 0);
        run_random(5, 100, 100);
        chk(state_o == 2'd0, "R10", "no pending after reset", longint'(state_o), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule